// File: doc/BRIEF.md
# Two-Die Asynchronous SRAM Strobe Controller

This block sits between a synchronous host port and an asynchronous static RAM module made of two byte-wide dies. Both dies share one address bus, one bidirectional data bus and a common active-low output enable. Each die has its own active-low chip enable and its own active-low write enable. The host presents a byte address whose most significant bit picks the die and whose lower bits go onto the shared address bus. With the address it gives write data, a write/read flag and a single-cycle request strobe.

The controller turns each accepted request into a timed sequence of strobes. A write holds the selected die's enable and write enable low for a programmable number of clocks while the controller drives the data bus. The controller then keeps driving the bus for one recovery clock after both strobes rise. A read first enables the selected die for one clock with output enable still high, so the bus has a clear turnaround. It then lowers output enable for a programmable number of clocks and registers the bus value at the end of the last of them. Completion is signalled by a one-clock done pulse. Requests that arrive while a cycle is in progress are dropped.

Top module: `sram2_ctrl`

## Requirements
- R1: During reset, and on the clock after reset is applied, both die enables, both write enables and the output enable are high (1), and `done_o` and `busy_o` are low.
- R2: Host address bit 19 chooses the die: 0 lowers only `mem_en_n_o[0]`, 1 lowers only `mem_en_n_o[1]`. The other die's enable and write enable stay high for the whole cycle.
- R3: The two die enables are never low together while output enable is low.
- R4: In a write, the selected die's enable and write enable are low for exactly WR_WAIT clocks and output enable stays high. The write data from the request is on the bus and is taken by the selected die.
- R5: In a read, write enable stays high. The selected die's enable goes low one clock before output enable goes low, and output enable then stays low for exactly RD_WAIT clocks, so the enable is low for RD_WAIT+1 clocks.
- R6: The controller never drives the data bus while output enable is low. It drives the bus only during a write and the one recovery clock after it.
- R7: `rdata_o` holds the bus value sampled at the clock edge that ends the last output-enable-low clock. It is valid when `done_o` is high.
- R8: `done_o` is a one-clock pulse. Counting the accepting edge as edge 1, it rises on edge WR_WAIT+1 for a write and on edge RD_WAIT+2 for a read.
- R9: A request made while `busy_o` is high is ignored. It starts no strobe activity, writes nothing and produces no extra done pulse.
- R10: `mem_addr_o` equals host address bits 18:0 of the accepted request and does not change while the cycle is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken when not busy |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Byte address; bit 19 selects the die |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| done_o | output | 1 | One-clock completion pulse |
| busy_o | output | 1 | High while a cycle is in progress |
| mem_addr_o | output | 19 | Shared SRAM address bus |
| mem_en_n_o | output | 2 | Per-die active-low enable |
| mem_we_n_o | output | 2 | Per-die active-low write enable |
| mem_oe_n_o | output | 1 | Shared active-low output enable |
| mem_dq_io | inout | 8 | Shared bidirectional data bus |

## Verification
A wrong state or a wrong wait count shows up at the ports within a single transaction. The done pulse arrives on the wrong edge, and the number of clocks with write enable or output enable low no longer matches the parameters. A wrong die decode lowers the wrong enable, which shows as data written to or read from the other die on the next read-back. The bench's memory model returns a poison byte until output enable has been low for the full access time. An access wait that is too short therefore shows as wrong read data on that same read. A bus driven during output enable shows at once as a contention check failing on that clock.

// File: rtl/sram2_pkg.sv
`timescale 1ns/1ps
package sram2_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRITE = 3'd1,
      ST_WREC  = 3'd2,
      ST_RTURN = 3'd3,
      ST_RACT  = 3'd4
   } sram2_state_e;
endpackage

// File: rtl/sram2_die_decode.sv
`timescale 1ns/1ps
// Turns the registered die select and activity flags into per-die active-low strobes.
module sram2_die_decode #(
   parameter int NDIE = 2,
   parameter int SELW = 1
) (
   input  logic [SELW-1:0] sel,
   input  logic            en_act,
   input  logic            we_act,
   output logic [NDIE-1:0] en_n,
   output logic [NDIE-1:0] we_n
);
   for (genvar d = 0; d < NDIE; d++) begin : g_die
      assign en_n[d] = !(en_act && (sel == SELW'(d)));
      assign we_n[d] = !(we_act && (sel == SELW'(d)));
   end
endmodule

// File: rtl/sram2_wait_cnt.sv
`timescale 1ns/1ps
// Down-counter for access waits; holds at zero.
module sram2_wait_cnt #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram2_dq_port.sv
`timescale 1ns/1ps
// Tri-state data bus driver and read capture register.
module sram2_dq_port #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          drive,
   input  logic [DW-1:0] wdata,
   input  logic          sample,
   output logic [DW-1:0] rdata,
   inout  wire  [DW-1:0] dq
);
   assign dq = drive ? wdata : {DW{1'bz}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (sample) rdata <= dq;
   end
endmodule

// File: rtl/sram2_ctrl.sv
`timescale 1ns/1ps
module sram2_ctrl
   import sram2_pkg::*;
#(
   parameter  int AW      = 19,
   parameter  int DW      = 8,
   parameter  int NDIE    = 2,
   parameter  int RD_WAIT = 3,
   parameter  int WR_WAIT = 2,
   localparam int SELW    = $clog2(NDIE),
   localparam int HAW     = AW + SELW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic            we_i,
   input  logic [HAW-1:0]  addr_i,
   input  logic [DW-1:0]   wdata_i,
   output logic [DW-1:0]   rdata_o,
   output logic            done_o,
   output logic            busy_o,
   output logic [AW-1:0]   mem_addr_o,
   output logic [NDIE-1:0] mem_en_n_o,
   output logic [NDIE-1:0] mem_we_n_o,
   output logic            mem_oe_n_o,
   inout  wire  [DW-1:0]   mem_dq_io
);
   localparam int MAXW = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
   localparam int CW   = $clog2(MAXW + 1);

   // elaboration-time parameter checks
   if (NDIE < 2 || (1 << SELW) != NDIE) begin : g_bad_ndie
      $error("NDIE must be a power of two of at least 2");
   end
   if (RD_WAIT < 1 || WR_WAIT < 1) begin : g_bad_wait
      $error("wait counts must be at least 1");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("address and data widths must be positive");
   end

   sram2_state_e    state_q;
   logic [AW-1:0]   addr_q;
   logic [SELW-1:0] sel_q;
   logic [DW-1:0]   wdata_q;
   logic            en_act_q;
   logic            we_act_q;
   logic            oe_act_q;
   logic            bus_drive;
   logic            done_q;
   logic            cnt_load;
   logic [CW-1:0]   cnt_val;
   logic            cnt_zero;
   logic            rd_sample;

   // counter load: write wait on acceptance, read wait on turnaround clock
   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = CW'(WR_WAIT - 1);
      if (state_q == ST_IDLE && req_i && we_i) begin
         cnt_load = 1'b1;
      end else if (state_q == ST_RTURN) begin
         cnt_load = 1'b1;
         cnt_val  = CW'(RD_WAIT - 1);
      end
   end

   assign rd_sample = (state_q == ST_RACT) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         sel_q     <= '0;
         wdata_q   <= '0;
         en_act_q  <= 1'b0;
         we_act_q  <= 1'b0;
         oe_act_q  <= 1'b0;
         bus_drive <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  addr_q   <= addr_i[AW-1:0];
                  sel_q    <= addr_i[HAW-1:AW];
                  wdata_q  <= wdata_i;
                  en_act_q <= 1'b1;
                  if (we_i) begin
                     we_act_q  <= 1'b1;
                     bus_drive <= 1'b1;
                     state_q   <= ST_WRITE;
                  end else begin
                     state_q   <= ST_RTURN;
                  end
               end
            end
            ST_WRITE: begin
               if (cnt_zero) begin
                  en_act_q <= 1'b0;
                  we_act_q <= 1'b0;
                  done_q   <= 1'b1;
                  state_q  <= ST_WREC;
               end
            end
            ST_WREC: begin
               bus_drive <= 1'b0;
               state_q   <= ST_IDLE;
            end
            ST_RTURN: begin
               oe_act_q <= 1'b1;
               state_q  <= ST_RACT;
            end
            ST_RACT: begin
               if (cnt_zero) begin
                  oe_act_q <= 1'b0;
                  en_act_q <= 1'b0;
                  done_q   <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   sram2_wait_cnt #(.CW(CW)) wait_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .zero     (cnt_zero)
   );

   sram2_die_decode #(.NDIE(NDIE), .SELW(SELW)) dec_i (
      .sel    (sel_q),
      .en_act (en_act_q),
      .we_act (we_act_q),
      .en_n   (mem_en_n_o),
      .we_n   (mem_we_n_o)
   );

   sram2_dq_port #(.DW(DW)) dq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .drive  (bus_drive),
      .wdata  (wdata_q),
      .sample (rd_sample),
      .rdata  (rdata_o),
      .dq     (mem_dq_io)
   );

   assign mem_addr_o = addr_q;
   assign mem_oe_n_o = !oe_act_q;
   assign done_o     = done_q;
   assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/sram2_ctrl_chk.sv
`timescale 1ns/1ps
module sram2_ctrl_chk #(
   parameter int AW   = 19,
   parameter int NDIE = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:0]   mem_addr_o,
   input logic [NDIE-1:0] mem_en_n_o,
   input logic [NDIE-1:0] mem_we_n_o,
   input logic            mem_oe_n_o,
   input logic            done_o,
   input logic            busy_o,
   input logic            bus_drive
);
   // R2: at most one die enabled; a write strobe only on the enabled die
   assert_one_die_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~mem_en_n_o) <= 1);
   assert_we_on_en_die_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((~mem_we_n_o) & mem_en_n_o) == '0);
   // R3: no two dies enabled while outputs are on
   assert_single_reader_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n_o |-> $onehot0(~mem_en_n_o));
   // R4: output enable stays high during a write strobe
   assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_n_o != '1) |-> mem_oe_n_o);
   // R5: enable already low on the clock before output enable falls
   assert_read_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n_o && $past(mem_oe_n_o)) |-> ($past(mem_en_n_o) != '1));
   // R6: the controller never drives while output enable is low
   assert_no_drive_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n_o |-> !bus_drive);
   // R8: done lasts one clock
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R10: address held through a busy cycle
   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));
endmodule

bind sram2_ctrl sram2_ctrl_chk #(.AW(AW), .NDIE(NDIE)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_addr_o (mem_addr_o),
   .mem_en_n_o (mem_en_n_o),
   .mem_we_n_o (mem_we_n_o),
   .mem_oe_n_o (mem_oe_n_o),
   .done_o     (done_o),
   .busy_o     (busy_o),
   .bus_drive  (bus_drive)
);

// File: tb/sram2_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram2_ctrl_tb_top;
   localparam int RDW = 3;
   localparam int WRW = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [19:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        done, busy;
   logic [18:0] maddr;
   logic [1:0]  en_n, we_n;
   logic        oe_n;
   wire  [7:0]  dq;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   sram2_ctrl #(.RD_WAIT(RDW), .WR_WAIT(WRW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .busy_o(busy),
      .mem_addr_o(maddr), .mem_en_n_o(en_n), .mem_we_n_o(we_n),
      .mem_oe_n_o(oe_n), .mem_dq_io(dq)
   );

   // memory model: 16 bytes per die, poison until access time is met
   logic [7:0] mem [2][16];
   int         acc_cnt = 0;
   logic       m_drive;
   logic       m_die;
   logic [7:0] m_data;
   assign m_die   = en_n[0];
   assign m_drive = !oe_n && (en_n != 2'b11) && (we_n == 2'b11);
   assign m_data  = (acc_cnt >= RDW) ? mem[m_die][maddr[3:0]] : 8'hEE;
   assign dq      = m_drive ? m_data : 8'bz;

   initial begin
      for (int d = 0; d < 2; d++)
         for (int i = 0; i < 16; i++) mem[d][i] = 8'h00;
   end

   always @(negedge clk) begin
      acc_cnt <= oe_n ? 0 : acc_cnt + 1;
      for (int d = 0; d < 2; d++)
         if (!en_n[d] && !we_n[d]) mem[d][maddr[3:0]] <= dq;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one transaction; optional poke of a second request while busy
   task automatic txn(input bit w, input logic [19:0] a, input logic [7:0] wd,
                      input bit poke,
                      output logic [7:0] rd, output int cyc, output int we_lo,
                      output int oe_lo, output int en_lo, output logic [1:0] dmask,
                      output bit addr_ok, output int dones, output bit idle_ok);
      cyc = 0; we_lo = 0; oe_lo = 0; en_lo = 0; dmask = 2'b00;
      addr_ok = 1'b1; dones = 0; idle_ok = 1'b1; rd = '0;
      @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = wd;
      @(negedge clk);
      req = 1'b0;
      for (int k = 0; k < 60; k++) begin
         if (k > 0) @(negedge clk);
         if (poke && k == 0) begin
            req = 1'b1; we = 1'b1; addr = 20'h80009; wdata = 8'h99;
         end else begin
            req = 1'b0;
         end
         cyc++;
         if (we_n != 2'b11) we_lo++;
         if (!oe_n) oe_lo++;
         if (en_n != 2'b11) begin
            en_lo++;
            if (maddr != a[18:0]) addr_ok = 1'b0;
         end
         dmask |= ~en_n;
         if (done) begin
            dones++;
            rd = rdata;
            break;
         end
      end
      req = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (done) dones++;
         if (k >= 1 && (en_n != 2'b11 || oe_n != 1'b1)) idle_ok = 1'b0;
      end
   endtask

   // {we, addr[19:0], wdata, expected read}
   localparam logic [36:0] VEC [11] = '{
      {1'b1, 20'h00003, 8'hA5, 8'h00},
      {1'b1, 20'h80003, 8'h5A, 8'h00},
      {1'b1, 20'h7FFFF, 8'h3C, 8'h00},
      {1'b1, 20'hFFFFF, 8'hC3, 8'h00},
      {1'b0, 20'h00003, 8'h00, 8'hA5},
      {1'b0, 20'h80003, 8'h00, 8'h5A},
      {1'b0, 20'h7FFFF, 8'h00, 8'h3C},
      {1'b0, 20'hFFFFF, 8'h00, 8'hC3},
      {1'b1, 20'h00003, 8'h0F, 8'h00},
      {1'b0, 20'h00003, 8'h00, 8'h0F},
      {1'b0, 20'h80003, 8'h00, 8'h5A}
   };

   bit finished = 1'b0;

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      logic [1:0] dm;
      int cyc, wl, ol, el, dn;
      bit aok, iok;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(en_n == 2'b11 && we_n == 2'b11 && oe_n, "R1 strobes in reset",
          {en_n, we_n, oe_n}, 5'h1F);
      chk(!done && !busy, "R1 done/busy in reset", {done, busy}, 0);
      rst_n = 1'b1;

      foreach (VEC[i]) begin
         logic        vw;
         logic [19:0] va;
         logic [7:0]  vd, ve;
         vw = VEC[i][36]; va = VEC[i][35:16]; vd = VEC[i][15:8]; ve = VEC[i][7:0];
         txn(vw, va, vd, 1'b0, rd, cyc, wl, ol, el, dm, aok, dn, iok);
         chk(dm == (va[19] ? 2'b10 : 2'b01), $sformatf("R2 die mask vec%0d", i), dm,
             va[19] ? 2 : 1);
         chk(aok, $sformatf("R10 address vec%0d", i), aok, 1);
         chk(dn == 1, $sformatf("R8 single done vec%0d", i), dn, 1);
         if (vw) begin
            chk(cyc == WRW + 1, $sformatf("R8 write latency vec%0d", i), cyc, WRW + 1);
            chk(wl == WRW && el == WRW, $sformatf("R4 write strobe length vec%0d", i),
                wl, WRW);
            chk(ol == 0, $sformatf("R4 oe high in write vec%0d", i), ol, 0);
         end else begin
            chk(cyc == RDW + 2, $sformatf("R8 read latency vec%0d", i), cyc, RDW + 2);
            chk(ol == RDW, $sformatf("R5 oe low length vec%0d", i), ol, RDW);
            chk(el == RDW + 1, $sformatf("R5 enable lead vec%0d", i), el, RDW + 1);
            chk(wl == 0, $sformatf("R5 no write strobe vec%0d", i), wl, 0);
            chk(rd == ve, $sformatf("R7 read data vec%0d", i), rd, ve);
         end
      end

      // R4: data reached the selected die only
      chk(mem[0][3] == 8'h0F && mem[1][3] == 8'h5A, "R4 data in die arrays",
          {mem[0][3], mem[1][3]}, 16'h0F5A);

      // R9: request while busy is ignored
      txn(1'b1, 20'h00009, 8'h11, 1'b1, rd, cyc, wl, ol, el, dm, aok, dn, iok);
      chk(dn == 1, "R9 one done despite busy request", dn, 1);
      chk(iok, "R9 no strobes after ignored request", iok, 1);
      chk(dm == 2'b01, "R9 only die0 touched", dm, 1);
      txn(1'b0, 20'h80009, 8'h00, 1'b0, rd, cyc, wl, ol, el, dm, aok, dn, iok);
      chk(rd == 8'h00, "R9 ignored write left die1 unchanged", rd, 0);
      txn(1'b0, 20'h00009, 8'h00, 1'b0, rd, cyc, wl, ol, el, dm, aok, dn, iok);
      chk(rd == 8'h11, "R7 accepted write read back", rd, 8'h11);

      // R6: no contention on the bus during a read (model drive never meets X)
      chk(!$isunknown(rd), "R6 clean bus on read", rd, 8'h11);

      // R1: reset in the middle of a write
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 20'h80001; wdata = 8'h77;
      @(negedge clk);
      req = 1'b0;
      chk(en_n == 2'b01 && we_n == 2'b01, "R2 die1 write strobes", {en_n, we_n}, 4'h5);
      rst_n = 1'b0;
      @(negedge clk);
      chk(en_n == 2'b11 && we_n == 2'b11 && oe_n && !busy && !done,
          "R1 strobes released by reset", {en_n, we_n, oe_n, busy, done}, 7'h7C);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule